// File: doc/BRIEF.md
# Stop-Mode Clock Gating Controller

This block sits inside a microcontroller clock generator. It controls the enable of the main oscillator and the enables of all clocks derived from it: the bus clock, the divided peripheral clocks and the converter clock. Software writing a one into the stop bit of the control register puts the block into stop mode. In stop mode the oscillator enable and every derived enable are held low. The block leaves stop mode on a reset, on a non-maskable interrupt, or on an enabled interrupt request whose priority is strictly above a programmable 3-bit exit threshold.

On wake-up the stop bit clears at once and the oscillator enable returns first. A stabilization counter of `STAB_CYC` cycles then runs, and only after it expires are the derived clock enables released. Stop entry and reset both load the main clock division register with 8'h08. The block also selects which internal clock or strobe drives a shared clock-output pin. The selection depends on single-chip or expansion operation, and any clock routed to the pin is forced low while the derived clocks are stopped.

Top module: `clkstop_ctrl`

## Requirements
- R1: While running (all `dclk_en` high), a cycle with `ctl_wr`=1 and `ctl_wdata[0]`=1 sets `stop_flag` and drives `osc_en` and all `dclk_en` low from the next clock edge onward.
- R2: Whenever `stop_flag` is 1, `osc_en` is 0 and every bit of `dclk_en` is 0.
- R3: In stop mode, interrupt line i wakes the block only when `irq_req[i]`, `irq_en[i]` and `irq_prio[3*i+2:3*i]` > threshold all hold. The comparison is unsigned and strict. The threshold is written from `thr_wdata` when `thr_wr` is 1. A request at a priority equal to the threshold, or on a disabled line, leaves the block stopped.
- R4: `nmi`=1 during stop mode ends stop mode at the next edge, whatever the threshold.
- R5: `div_q` becomes 8'h08 on reset and at the edge that enters stop mode. Otherwise a `div_wr` cycle loads `div_wdata`.
- R6: With `ext_mode`=0 the pin follows `pin_sel`: 00 hands the pin to general I/O (`pin_gpio`=1, `pin_val`=0), 01 outputs fc, 10 outputs f8 and 11 outputs f32. `ale_sel` and `bclk_dis` are ignored.
- R7: At the edge after a wake condition, `stop_flag` clears and `osc_en` rises while `dclk_en` stays 0. `dclk_en` becomes all ones exactly `STAB_CYC` edges after that.
- R8: With `ext_mode`=1, `ale_sel`=01 outputs the ALE strobe. Otherwise `bclk_dis`=0 outputs the bus clock. Otherwise `pin_sel` 00/01/10/11 outputs constant low/fc/f8/f32. `ale_sel` values 10 and 11 behave as 00.
- R9: A wake condition present in the same cycle as an accepted stop write is held as pending. The block enters stop for one cycle and then starts its wake sequence, even if the request has gone.
- R10: When `dclk_en` is low, every clock source routed to the pin reads as 0. The general I/O selection is unaffected.
- R11: A synchronous active-high `rst` returns the block to running with `stop_flag`=0 and `osc_en` and `dclk_en` high, and clears the exit threshold to 0.
- R12: A control write with `ctl_wdata[0]`=0, or any control write while not running, leaves the stop state and wake sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data, bit 0 is the stop request |
| thr_wr | input | 1 | Exit threshold write strobe |
| thr_wdata | input | 3 | New exit threshold |
| div_wr | input | 1 | Division register write strobe |
| div_wdata | input | 8 | New division register value |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Interrupt enables |
| irq_prio | input | 3*NUM_IRQ | Per-line priority, 3 bits each, line 0 lowest |
| nmi | input | 1 | Non-maskable interrupt |
| ext_mode | input | 1 | 1 selects expansion operation |
| bclk_dis | input | 1 | Bus clock output disable |
| ale_sel | input | 2 | ALE pin selection |
| pin_sel | input | 2 | Clock output selection |
| src_fc | input | 1 | fc clock level |
| src_f8 | input | 1 | f8 clock level |
| src_f32 | input | 1 | f32 clock level |
| src_bclk | input | 1 | Bus clock level |
| src_ale | input | 1 | ALE strobe level |
| osc_en | output | 1 | Main oscillator enable |
| dclk_en | output | NUM_DCLK | Derived clock enables |
| stop_flag | output | 1 | Stop bit state |
| div_q | output | 8 | Main clock division register |
| pin_gpio | output | 1 | Pin handed to general I/O |
| pin_val | output | 1 | Clock output pin value |

## Verification
The checks assume that a stop write arrives only as a one-cycle strobe and that priorities, enables and threshold are stable around the edge where a wake is judged. The bench changes inputs only one time unit after a rising edge and drops each strobe after one cycle. The assertions that relate entry and wake take `rst` as synchronous and the clock-source levels as ordinary data. The stimulus therefore treats those levels as static bits set per vector and never toggles them as real clocks.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int unsigned PRIO_W = 3;
    localparam logic [7:0] DIV_RESET = 8'h08;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOP    = 2'd1,
        ST_OSCWAIT = 2'd2
    } cs_state_e;

    typedef enum logic [1:0] {
        PS_LOW_OR_IO = 2'b00,
        PS_FC        = 2'b01,
        PS_F8        = 2'b10,
        PS_F32       = 2'b11
    } pin_sel_e;

    typedef struct packed {
        logic       ext_mode;
        logic       bclk_dis;
        logic [1:0] ale_sel;
        pin_sel_e   sel;
    } pin_cfg_t;

    typedef struct packed {
        logic fc;
        logic f8;
        logic f32;
        logic bclk;
        logic ale;
    } clk_src_t;

    function automatic logic prio_above(input logic [PRIO_W-1:0] prio,
                                        input logic [PRIO_W-1:0] thr);
        return prio > thr;
    endfunction

endpackage

// File: rtl/clkstop_wake.sv
module clkstop_wake
    import clkstop_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]         thr,
    input  logic                      nmi,
    output logic                      wake
);
    logic [NUM_IRQ-1:0] qual;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign qual[i] = irq_req[i] && irq_en[i]
                      && prio_above(irq_prio[i*PRIO_W +: PRIO_W], thr);
    end

    assign wake = nmi || (|qual);
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int unsigned STAB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic stop_bit,
    input  logic wake,
    output logic enter_stop,
    output logic osc_en,
    output logic run,
    output logic stop_flag
);
    localparam int unsigned CW = $clog2(STAB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

    cs_state_e     state;
    logic [CW-1:0] cnt;
    logic          pend;

    assign enter_stop = (state == ST_RUN) && ctl_wr && stop_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (enter_stop) begin
                        state <= ST_STOP;
                        pend  <= wake;
                    end
                end
                ST_STOP: begin
                    if (wake || pend) begin
                        state <= ST_OSCWAIT;
                        cnt   <= '0;
                        pend  <= 1'b0;
                    end
                end
                ST_OSCWAIT: begin
                    if (cnt == LAST) state <= ST_RUN;
                    else             cnt   <= cnt + 1'b1;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign osc_en    = (state != ST_STOP);
    assign run       = (state == ST_RUN);
    assign stop_flag = (state == ST_STOP);
endmodule

// File: rtl/clkstop_regs.sv
module clkstop_regs
    import clkstop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              thr_wr,
    input  logic [PRIO_W-1:0] thr_wdata,
    input  logic              div_wr,
    input  logic [7:0]        div_wdata,
    input  logic              enter_stop,
    output logic [PRIO_W-1:0] thr_q,
    output logic [7:0]        div_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            div_q <= DIV_RESET;
        end else begin
            if (thr_wr) thr_q <= thr_wdata;
            if (enter_stop)  div_q <= DIV_RESET;
            else if (div_wr) div_q <= div_wdata;
        end
    end
endmodule

// File: rtl/clkstop_pinmux.sv
module clkstop_pinmux
    import clkstop_pkg::*;
(
    input  pin_cfg_t cfg,
    input  clk_src_t src,
    input  logic     run,
    output logic     pin_gpio,
    output logic     pin_val
);
    clk_src_t g;
    logic     sel_clk;

    assign g = run ? src : '0;

    always_comb begin
        unique case (cfg.sel)
            PS_FC:   sel_clk = g.fc;
            PS_F8:   sel_clk = g.f8;
            PS_F32:  sel_clk = g.f32;
            default: sel_clk = 1'b0;
        endcase
    end

    always_comb begin
        pin_gpio = 1'b0;
        pin_val  = 1'b0;
        if (!cfg.ext_mode) begin
            pin_gpio = (cfg.sel == PS_LOW_OR_IO);
            pin_val  = sel_clk;
        end else if (cfg.ale_sel == 2'b01) begin
            pin_val = g.ale;
        end else if (!cfg.bclk_dis) begin
            pin_val = g.bclk;
        end else begin
            pin_val = sel_clk;
        end
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = 8,
    parameter int unsigned NUM_DCLK = 8,
    parameter int unsigned STAB_CYC = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ctl_wr,
    input  logic [7:0]                ctl_wdata,
    input  logic                      thr_wr,
    input  logic [2:0]                thr_wdata,
    input  logic                      div_wr,
    input  logic [7:0]                div_wdata,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [3*NUM_IRQ-1:0]      irq_prio,
    input  logic                      nmi,
    input  logic                      ext_mode,
    input  logic                      bclk_dis,
    input  logic [1:0]                ale_sel,
    input  logic [1:0]                pin_sel,
    input  logic                      src_fc,
    input  logic                      src_f8,
    input  logic                      src_f32,
    input  logic                      src_bclk,
    input  logic                      src_ale,
    output logic                      osc_en,
    output logic [NUM_DCLK-1:0]       dclk_en,
    output logic                      stop_flag,
    output logic [7:0]                div_q,
    output logic                      pin_gpio,
    output logic                      pin_val
);
    logic              wake;
    logic              enter_stop;
    logic              run;
    logic [PRIO_W-1:0] thr_q;
    pin_cfg_t          cfg;
    clk_src_t          src;

    assign cfg = '{ext_mode: ext_mode, bclk_dis: bclk_dis,
                   ale_sel: ale_sel, sel: pin_sel_e'(pin_sel)};
    assign src = '{fc: src_fc, f8: src_f8, f32: src_f32,
                   bclk: src_bclk, ale: src_ale};

    clkstop_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .irq_prio(irq_prio),
        .thr     (thr_q),
        .nmi     (nmi),
        .wake    (wake)
    );

    clkstop_seq #(.STAB_CYC(STAB_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .stop_bit  (ctl_wdata[0]),
        .wake      (wake),
        .enter_stop(enter_stop),
        .osc_en    (osc_en),
        .run       (run),
        .stop_flag (stop_flag)
    );

    clkstop_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .thr_wr    (thr_wr),
        .thr_wdata (thr_wdata),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .enter_stop(enter_stop),
        .thr_q     (thr_q),
        .div_q     (div_q)
    );

    for (genvar d = 0; d < NUM_DCLK; d++) begin : g_dclk
        assign dclk_en[d] = run;
    end

    clkstop_pinmux u_pin (
        .cfg     (cfg),
        .src     (src),
        .run     (run),
        .pin_gpio(pin_gpio),
        .pin_val (pin_val)
    );
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
    parameter int unsigned NUM_DCLK = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                ctl_wr,
    input logic [7:0]          ctl_wdata,
    input logic                nmi,
    input logic                osc_en,
    input logic [NUM_DCLK-1:0] dclk_en,
    input logic                stop_flag,
    input logic [7:0]          div_q,
    input logic                pin_val
);
    assert_stop_entry_R1: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[0] && (&dclk_en)) |=> stop_flag);

    assert_stop_gates_R2: assert property (@(posedge clk) disable iff (rst)
        stop_flag |-> (!osc_en && dclk_en == '0));

    assert_nmi_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (stop_flag && nmi) |=> !stop_flag);

    assert_div_on_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_flag) |-> div_q == 8'h08);

    assert_osc_first_R7: assert property (@(posedge clk) disable iff (rst)
        (|dclk_en) |-> osc_en);

    assert_wake_order_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_flag) |-> (osc_en && dclk_en == '0));

    assert_pin_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        stop_flag |-> !pin_val);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NUM_DCLK(NUM_DCLK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_wdata(ctl_wdata),
    .nmi      (nmi),
    .osc_en   (osc_en),
    .dclk_en  (dclk_en),
    .stop_flag(stop_flag),
    .div_q    (div_q),
    .pin_val  (pin_val)
);

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
    localparam int NI = 8;
    localparam int ND = 8;
    localparam int SC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 0, thr_wr = 0, div_wr = 0, nmi = 0;
    logic [7:0] ctl_wdata = 0, div_wdata = 0;
    logic [2:0] thr_wdata = 0;
    logic [NI-1:0] irq_req = 0, irq_en = 0;
    logic [3*NI-1:0] irq_prio = 0;
    logic ext_mode = 0, bclk_dis = 0;
    logic [1:0] ale_sel = 0, pin_sel = 0;
    logic src_fc = 0, src_f8 = 0, src_f32 = 0, src_bclk = 0, src_ale = 0;
    logic osc_en, stop_flag, pin_gpio, pin_val;
    logic [ND-1:0] dclk_en;
    logic [7:0] div_q;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    clkstop_ctrl #(.NUM_IRQ(NI), .NUM_DCLK(ND), .STAB_CYC(SC)) i_clkstop_ctrl (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .thr_wr(thr_wr), .thr_wdata(thr_wdata), .div_wr(div_wr), .div_wdata(div_wdata),
        .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio), .nmi(nmi),
        .ext_mode(ext_mode), .bclk_dis(bclk_dis), .ale_sel(ale_sel), .pin_sel(pin_sel),
        .src_fc(src_fc), .src_f8(src_f8), .src_f32(src_f32), .src_bclk(src_bclk),
        .src_ale(src_ale), .osc_en(osc_en), .dclk_en(dclk_en), .stop_flag(stop_flag),
        .div_q(div_q), .pin_gpio(pin_gpio), .pin_val(pin_val)
    );

    // {ext, bclk_dis, ale_sel[1:0], pin_sel[1:0], src{fc,f8,f32,bclk,ale}, exp_gpio, exp_val}
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_0_00_00_11111_1_0,
        13'b0_0_00_01_10000_0_1,
        13'b0_0_00_01_01111_0_0,
        13'b0_0_00_10_01000_0_1,
        13'b0_0_00_11_00100_0_1,
        13'b0_0_01_11_11011_0_0,
        13'b1_0_00_01_00010_0_1,
        13'b1_0_00_01_11101_0_0,
        13'b1_1_00_00_11111_0_0,
        13'b1_1_00_01_10000_0_1,
        13'b1_1_00_10_01000_0_1,
        13'b1_1_00_11_00100_0_1,
        13'b1_0_01_00_00001_0_1,
        13'b1_1_01_11_11110_0_0
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic stop_write(input logic [7:0] d);
        ctl_wr = 1; ctl_wdata = d;
        tick();
        ctl_wr = 0; ctl_wdata = 0;
    endtask

    task automatic set_line(input int i, input logic [2:0] p, input logic en);
        irq_prio[i*3 +: 3] = p;
        irq_en[i] = en;
    endtask

    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 stop_flag", stop_flag, 0);
        chk("R11 osc_en", osc_en, 1);
        chk("R11 dclk_en", dclk_en, 8'hFF);
        chk("R5 div reset", div_q, 8'h08);

        // R6 R8 R10 pin mux table
        for (int v = 0; v < NV; v++) begin
            {ext_mode, bclk_dis, ale_sel, pin_sel,
             src_fc, src_f8, src_f32, src_bclk, src_ale} = VEC[v][12:2];
            #1;
            chk(VEC[v][12] ? "R8 pin_gpio" : "R6 pin_gpio", pin_gpio, VEC[v][1]);
            chk(VEC[v][12] ? "R8 pin_val" : "R6 pin_val", pin_val, VEC[v][0]);
        end

        // R5 write then R12 stop bit zero ignored
        div_wr = 1; div_wdata = 8'h33; tick(); div_wr = 0;
        chk("R5 div write", div_q, 8'h33);
        stop_write(8'hFE);
        chk("R12 zero bit no stop", stop_flag, 0);
        chk("R12 zero bit dclk", dclk_en, 8'hFF);

        // R1 entry, R2, R5 reload, R10 gating
        ext_mode = 0; pin_sel = 2'b01; src_fc = 1;
        thr_wr = 1; thr_wdata = 3'd2; tick(); thr_wr = 0;
        stop_write(8'h01);
        chk("R1 stop_flag", stop_flag, 1);
        chk("R2 osc_en", osc_en, 0);
        chk("R2 dclk_en", dclk_en, 0);
        chk("R5 div on entry", div_q, 8'h08);
        chk("R10 pin gated", pin_val, 0);

        // R3 equal priority and disabled line do not wake
        set_line(2, 3'd2, 1); irq_req[2] = 1;
        set_line(5, 3'd7, 0); irq_req[5] = 1;
        tick(); tick();
        chk("R3 equal prio stays", stop_flag, 1);
        chk("R3 disabled stays", osc_en, 0);
        irq_req = 0;

        // R3 + R7 qualifying wake and stabilization
        set_line(3, 3'd3, 1); irq_req[3] = 1;
        tick(); irq_req = 0;
        chk("R3 wake stop_flag", stop_flag, 0);
        chk("R7 osc first", osc_en, 1);
        chk("R7 dclk held", dclk_en, 0);
        stop_write(8'h01);   // R12 write while stabilising ignored
        tick(); tick();
        chk("R7 dclk before count end", dclk_en, 0);
        chk("R12 no re-stop", stop_flag, 0);
        tick();
        chk("R7 dclk released", dclk_en, 8'hFF);
        chk("R10 pin clock back", pin_val, 1);

        // R4 nmi wake with threshold 7
        thr_wr = 1; thr_wdata = 3'd7; tick(); thr_wr = 0;
        stop_write(8'h01);
        set_line(6, 3'd7, 1); irq_req[6] = 1; tick(); irq_req = 0;
        chk("R3 prio 7 at thr 7 stays", stop_flag, 1);
        nmi = 1; tick(); nmi = 0;
        chk("R4 nmi wake", stop_flag, 0);
        repeat (SC) tick();
        chk("R4 back running", dclk_en, 8'hFF);

        // R9 same-cycle pending wake
        nmi = 1; ctl_wr = 1; ctl_wdata = 8'h01; tick();
        nmi = 0; ctl_wr = 0; ctl_wdata = 0;
        chk("R9 entered stop", stop_flag, 1);
        tick();
        chk("R9 pending exit", stop_flag, 0);
        chk("R9 osc on", osc_en, 1);
        repeat (SC) tick();

        // R11 reset during stop clears threshold
        stop_write(8'h01);
        do_reset();
        chk("R11 reset leaves stop", stop_flag, 0);
        chk("R11 reset dclk", dclk_en, 8'hFF);
        stop_write(8'h01);
        set_line(1, 3'd1, 1); irq_req[1] = 1; tick(); irq_req = 0;
        chk("R11 thr cleared wake", stop_flag, 0);
        repeat (SC) tick();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule